// File: doc/BRIEF.md
# TMDS Period Decoder

This block sits behind word alignment and channel deskew in a TMDS receiver. Every pixel clock it takes one aligned 10-bit character from each of the three data lanes. It works out which period the link is in: control, video or data island. It then recovers what that period carries: the 2-bit control value of each lane, the 8-bit video byte of each lane, or the 4-bit auxiliary nibble of each lane.

The block starts out treating the stream as plain DVI. There, any character time that is not a control character is a pixel. It also watches control periods for a run of identical preamble characters. A run of at least `PREAMBLE_LEN` that is followed by a guard-band character marks the stream as HDMI. The guard characters are then swallowed and the decoder switches to the sub-decoder the preamble announced. The HDMI flag stays set until reset or resync.

A decode error flag marks any data-island character that is not a legal TERC4 code. All outputs are registered, so a character's result appears exactly one clock after the character is presented.

Top module: `tmds_period_decoder`

## Requirements
- R1: A character time counts as control only when all three lanes carry one of the four control characters. The 2-bit value {D1,D0} is coded 00=1101010100, 01=0010101011, 10=0101010100, 11=1010101011. Lane 0 gives hsync=D0 and vsync=D1. Lane 1 gives ctl[0]=D0 and ctl[1]=D1. Lane 2 gives ctl[2]=D0 and ctl[3]=D1. In a control character time both vde and ade go low.
- R2: Before HDMI detection, every non-control character time drives vde high and ade low. Each lane's byte is decoded as follows. If bit 9 is set, bits 7:0 are inverted first. Then bit i is d[i]^d[i-1] when bit 8 is 1, or ~(d[i]^d[i-1]) when bit 8 is 0, with bit 0 passed through.
- R3: After at least `PREAMBLE_LEN` (default 8) consecutive control times with ctl=4'b0001 (video preamble), a character with 0100110011 on lane 1 sets is_hdmi. That character and the next `GUARD_LEN-1` characters (default 2 in total) give vde=ade=0 and zero payload. The characters after them are decoded as video with vde=1 and ade=0.
- R4: The same sequence with ctl=4'b0101 (island preamble) leads to data-island decoding. Here ade=1, vde=0, and each lane's nibble is the index of its character in the TERC4 table.
- R5: A preamble run shorter than `PREAMBLE_LEN` does not start HDMI handling. The same applies to a run whose type changes partway, because the count restarts. The guard character that follows is then decoded as an ordinary pixel (lane 1 value 0100110011 gives 8'h55).
- R6: is_hdmi, once set, holds until reset or resync.
- R7: In a data-island character time, a lane whose character is not in the TERC4 table yields nibble 0 and sets dec_err for that cycle. Valid lanes still decode. dec_err is never high outside data-island output cycles.
- R8: Inside a data island, a character with 0100110011 on lane 1 is a guard band: ade=0, no error, zero payload. A control character time ends a video or data-island period.
- R9: Every output is registered with one cycle of latency. After rst_n low or resync high, all outputs are zero and the block is back in DVI mode.
- R10: The video bytes read zero whenever vde is low, and the nibbles read zero whenever ade is low. hsync, vsync and ctl hold the value from the last control character time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| resync | input | 1 | Synchronous clear, active high |
| sym_ch0 | input | 10 | Aligned character, lane 0 |
| sym_ch1 | input | 10 | Aligned character, lane 1 |
| sym_ch2 | input | 10 | Aligned character, lane 2 |
| pix_ch0 | output | 8 | Video byte, lane 0 |
| pix_ch1 | output | 8 | Video byte, lane 1 |
| pix_ch2 | output | 8 | Video byte, lane 2 |
| aux_ch0 | output | 4 | Island nibble, lane 0 |
| aux_ch1 | output | 4 | Island nibble, lane 1 |
| aux_ch2 | output | 4 | Island nibble, lane 2 |
| hsync | output | 1 | Lane 0 control bit D0 |
| vsync | output | 1 | Lane 0 control bit D1 |
| ctl | output | 4 | Control bus from lanes 1 and 2 |
| vde | output | 1 | Video period output valid |
| ade | output | 1 | Data-island output valid |
| is_hdmi | output | 1 | 1 = HDMI stream detected, 0 = DVI |
| dec_err | output | 1 | Invalid TERC4 character seen |

## Verification
A wrong preamble count or period state shows at the ports on the first non-control character after a control period. In that cycle a guard band is delivered as a pixel, a data island is decoded as video, or is_hdmi fails to rise, and each of these is visible one clock after the character. A lost HDMI flag or a stale island state shows up the next time payload is decoded, as vde/ade pointing at the wrong sub-decoder. Sweeps over every pixel encoding mode and every 10-bit lane-0 value inside an island expose table or chain-decode faults on the very character that hits them.

// File: rtl/tmds_period_pkg.sv
package tmds_period_pkg;

   localparam int CHAR_W    = 10;
   localparam int PIX_W     = 8;
   localparam int NIB_W     = 4;
   localparam int NUM_LANES = 3;
   localparam int CTRL_W    = 2;

   // lane 1 character marking a guard band (leading or trailing)
   localparam logic [CHAR_W-1:0] GUARD_LANE1 = 10'b0100110011;

   // control bus values that announce a period
   localparam logic [3:0] PRE_VIDEO  = 4'b0001;
   localparam logic [3:0] PRE_ISLAND = 4'b0101;

   typedef enum logic [1:0] {
      SEL_CTRL   = 2'd0,
      SEL_SKIP   = 2'd1,
      SEL_VIDEO  = 2'd2,
      SEL_ISLAND = 2'd3
   } sel_e;

   typedef enum logic [1:0] {
      ST_CTRL   = 2'd0,
      ST_GUARD  = 2'd1,
      ST_VIDEO  = 2'd2,
      ST_ISLAND = 2'd3
   } period_e;

   typedef struct packed {
      logic              is_ctrl;
      logic [CTRL_W-1:0] ctrl;
      logic [PIX_W-1:0]  pix;
      logic              nib_ok;
      logic [NIB_W-1:0]  nib;
   } lane_dec_t;

   function automatic logic [CHAR_W-1:0] ctrl_code(input logic [CTRL_W-1:0] v);
      logic [CHAR_W-1:0] c;
      case (v)
         2'b00:   c = 10'b1101010100;
         2'b01:   c = 10'b0010101011;
         2'b10:   c = 10'b0101010100;
         default: c = 10'b1010101011;
      endcase
      return c;
   endfunction

   function automatic logic is_ctrl_char(input logic [CHAR_W-1:0] c);
      logic hit;
      hit = 1'b0;
      for (int v = 0; v < 4; v++) begin
         if (c == ctrl_code(CTRL_W'(v))) hit = 1'b1;
      end
      return hit;
   endfunction

   function automatic logic [CHAR_W-1:0] terc4_code(input logic [NIB_W-1:0] n);
      logic [CHAR_W-1:0] c;
      case (n)
         4'h0:    c = 10'b1010011100;
         4'h1:    c = 10'b1001100011;
         4'h2:    c = 10'b1011100100;
         4'h3:    c = 10'b1011100010;
         4'h4:    c = 10'b0101110001;
         4'h5:    c = 10'b0100011110;
         4'h6:    c = 10'b0110001110;
         4'h7:    c = 10'b0100111100;
         4'h8:    c = 10'b1011001100;
         4'h9:    c = 10'b0100111001;
         4'hA:    c = 10'b0110011100;
         4'hB:    c = 10'b1011000110;
         4'hC:    c = 10'b1010001110;
         4'hD:    c = 10'b1001110001;
         4'hE:    c = 10'b0101100011;
         default: c = 10'b1011000011;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/tmds_lane_dec.sv
module tmds_lane_dec
   import tmds_period_pkg::*;
(
   input  logic [CHAR_W-1:0] sym,
   output lane_dec_t         dec
);

   localparam int NUM_CTRL  = 1 << CTRL_W;
   localparam int NUM_TERC4 = 1 << NIB_W;

   logic [PIX_W-1:0] unrolled;
   lane_dec_t        d_c;

   // inversion undone before the transition chain
   assign unrolled = sym[9] ? ~sym[PIX_W-1:0] : sym[PIX_W-1:0];

   always_comb begin
      d_c = '0;
      for (int v = 0; v < NUM_CTRL; v++) begin
         if (sym == ctrl_code(CTRL_W'(v))) begin
            d_c.is_ctrl = 1'b1;
            d_c.ctrl    = CTRL_W'(v);
         end
      end
      d_c.pix[0] = unrolled[0];
      for (int i = 1; i < PIX_W; i++) begin
         d_c.pix[i] = sym[8] ? (unrolled[i] ^ unrolled[i-1])
                             : ~(unrolled[i] ^ unrolled[i-1]);
      end
      for (int n = 0; n < NUM_TERC4; n++) begin
         if (sym == terc4_code(NIB_W'(n))) begin
            d_c.nib_ok = 1'b1;
            d_c.nib    = NIB_W'(n);
         end
      end
   end

   assign dec = d_c;

endmodule

// File: rtl/tmds_period_fsm.sv
module tmds_period_fsm
   import tmds_period_pkg::*;
#(
   parameter int PREAMBLE_LEN = 8,
   parameter int GUARD_LEN    = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       resync,
   input  logic       all_ctrl,
   input  logic [3:0] ctl_bus,
   input  logic       guard_seen,
   output sel_e       sel,
   output logic       hdmi
);

   localparam int PCW = $clog2(PREAMBLE_LEN + 1);
   localparam int GCW = (GUARD_LEN < 2) ? 1 : $clog2(GUARD_LEN + 1);
   localparam logic [PCW-1:0] PRE_FULL  = PCW'(PREAMBLE_LEN);
   localparam logic [GCW-1:0] GUARD_TOP = GCW'(GUARD_LEN - 1);

   period_e        st_q, st_d;
   logic [PCW-1:0] pcnt_q, pcnt_d;
   logic [GCW-1:0] gcnt_q, gcnt_d;
   logic           kind_q, kind_d;   // 1: island preamble run
   logic           tgt_q, tgt_d;     // 1: island follows the guard
   logic           hdmi_q, hdmi_d;
   logic           is_vpre, is_ipre;

   assign is_vpre = (ctl_bus == PRE_VIDEO);
   assign is_ipre = (ctl_bus == PRE_ISLAND);

   always_comb begin
      sel    = SEL_CTRL;
      st_d   = st_q;
      pcnt_d = pcnt_q;
      gcnt_d = gcnt_q;
      kind_d = kind_q;
      tgt_d  = tgt_q;
      hdmi_d = hdmi_q;
      if (all_ctrl) begin
         sel    = SEL_CTRL;
         st_d   = ST_CTRL;
         gcnt_d = '0;
         if (is_vpre || is_ipre) begin
            if (pcnt_q != '0 && kind_q == is_ipre) begin
               if (pcnt_q != PRE_FULL) pcnt_d = pcnt_q + PCW'(1);
            end else begin
               pcnt_d = PCW'(1);
               kind_d = is_ipre;
            end
         end else begin
            pcnt_d = '0;
         end
      end else begin
         pcnt_d = '0;
         case (st_q)
            ST_CTRL: begin
               if (pcnt_q == PRE_FULL && guard_seen) begin
                  sel    = SEL_SKIP;
                  hdmi_d = 1'b1;
                  tgt_d  = kind_q;
                  if (GUARD_LEN == 1) begin
                     st_d = kind_q ? ST_ISLAND : ST_VIDEO;
                  end else begin
                     st_d   = ST_GUARD;
                     gcnt_d = GCW'(1);
                  end
               end else begin
                  sel  = SEL_VIDEO;
                  st_d = ST_VIDEO;
               end
            end
            ST_GUARD: begin
               sel    = SEL_SKIP;
               gcnt_d = gcnt_q + GCW'(1);
               if (gcnt_q == GUARD_TOP) st_d = tgt_q ? ST_ISLAND : ST_VIDEO;
            end
            ST_VIDEO: sel = SEL_VIDEO;
            default:  sel = guard_seen ? SEL_SKIP : SEL_ISLAND;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_CTRL;
         pcnt_q <= '0;
         gcnt_q <= '0;
         kind_q <= 1'b0;
         tgt_q  <= 1'b0;
         hdmi_q <= 1'b0;
      end else if (resync) begin
         st_q   <= ST_CTRL;
         pcnt_q <= '0;
         gcnt_q <= '0;
         kind_q <= 1'b0;
         tgt_q  <= 1'b0;
         hdmi_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         pcnt_q <= pcnt_d;
         gcnt_q <= gcnt_d;
         kind_q <= kind_d;
         tgt_q  <= tgt_d;
         hdmi_q <= hdmi_d;
      end
   end

   assign hdmi = hdmi_q;

endmodule

// File: rtl/tmds_period_decoder.sv
module tmds_period_decoder
   import tmds_period_pkg::*;
#(
   parameter int PREAMBLE_LEN = 8,
   parameter int GUARD_LEN    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              resync,
   input  logic [CHAR_W-1:0] sym_ch0,
   input  logic [CHAR_W-1:0] sym_ch1,
   input  logic [CHAR_W-1:0] sym_ch2,
   output logic [PIX_W-1:0]  pix_ch0,
   output logic [PIX_W-1:0]  pix_ch1,
   output logic [PIX_W-1:0]  pix_ch2,
   output logic [NIB_W-1:0]  aux_ch0,
   output logic [NIB_W-1:0]  aux_ch1,
   output logic [NIB_W-1:0]  aux_ch2,
   output logic              hsync,
   output logic              vsync,
   output logic [3:0]        ctl,
   output logic              vde,
   output logic              ade,
   output logic              is_hdmi,
   output logic              dec_err
);

   if (PREAMBLE_LEN < 1) begin : g_bad_pre
      $error("PREAMBLE_LEN must be at least 1");
   end
   if (GUARD_LEN < 1) begin : g_bad_guard
      $error("GUARD_LEN must be at least 1");
   end

   logic [CHAR_W-1:0]    sym [NUM_LANES];
   lane_dec_t            dec [NUM_LANES];
   logic [NUM_LANES-1:0] lane_ctrl;
   logic [NUM_LANES-1:0] lane_nib_ok;
   logic                 all_ctrl;
   logic [3:0]           ctl_bus;
   sel_e                 sel;
   logic                 hdmi;

   logic [PIX_W-1:0] pix_q [NUM_LANES];
   logic [NIB_W-1:0] aux_q [NUM_LANES];
   logic             hs_q, vs_q, vde_q, ade_q, err_q;
   logic [3:0]       ctl_q;

   assign sym[0] = sym_ch0;
   assign sym[1] = sym_ch1;
   assign sym[2] = sym_ch2;

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      tmds_lane_dec u_lane (
         .sym (sym[l]),
         .dec (dec[l])
      );
      assign lane_ctrl[l]   = dec[l].is_ctrl;
      assign lane_nib_ok[l] = dec[l].nib_ok;
   end

   assign all_ctrl = &lane_ctrl;
   assign ctl_bus  = {dec[2].ctrl, dec[1].ctrl};

   tmds_period_fsm #(
      .PREAMBLE_LEN (PREAMBLE_LEN),
      .GUARD_LEN    (GUARD_LEN)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .resync     (resync),
      .all_ctrl   (all_ctrl),
      .ctl_bus    (ctl_bus),
      .guard_seen (sym_ch1 == GUARD_LANE1),
      .sel        (sel),
      .hdmi       (hdmi)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int l = 0; l < NUM_LANES; l++) begin
            pix_q[l] <= '0;
            aux_q[l] <= '0;
         end
         hs_q  <= 1'b0;
         vs_q  <= 1'b0;
         ctl_q <= '0;
         vde_q <= 1'b0;
         ade_q <= 1'b0;
         err_q <= 1'b0;
      end else if (resync) begin
         for (int l = 0; l < NUM_LANES; l++) begin
            pix_q[l] <= '0;
            aux_q[l] <= '0;
         end
         hs_q  <= 1'b0;
         vs_q  <= 1'b0;
         ctl_q <= '0;
         vde_q <= 1'b0;
         ade_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         vde_q <= (sel == SEL_VIDEO);
         ade_q <= (sel == SEL_ISLAND);
         err_q <= (sel == SEL_ISLAND) && !(&lane_nib_ok);
         for (int l = 0; l < NUM_LANES; l++) begin
            pix_q[l] <= (sel == SEL_VIDEO) ? dec[l].pix : '0;
            aux_q[l] <= (sel == SEL_ISLAND && dec[l].nib_ok) ? dec[l].nib : '0;
         end
         if (sel == SEL_CTRL) begin
            hs_q  <= dec[0].ctrl[0];
            vs_q  <= dec[0].ctrl[1];
            ctl_q <= ctl_bus;
         end
      end
   end

   assign pix_ch0 = pix_q[0];
   assign pix_ch1 = pix_q[1];
   assign pix_ch2 = pix_q[2];
   assign aux_ch0 = aux_q[0];
   assign aux_ch1 = aux_q[1];
   assign aux_ch2 = aux_q[2];
   assign hsync   = hs_q;
   assign vsync   = vs_q;
   assign ctl     = ctl_q;
   assign vde     = vde_q;
   assign ade     = ade_q;
   assign is_hdmi = hdmi;
   assign dec_err = err_q;

endmodule

// File: rtl/tmds_period_decoder_chk.sv
module tmds_period_decoder_chk
   import tmds_period_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              resync,
   input logic [CHAR_W-1:0] sym_ch0,
   input logic [CHAR_W-1:0] sym_ch1,
   input logic [CHAR_W-1:0] sym_ch2,
   input logic [PIX_W-1:0]  pix_ch0,
   input logic [PIX_W-1:0]  pix_ch1,
   input logic [PIX_W-1:0]  pix_ch2,
   input logic [NIB_W-1:0]  aux_ch0,
   input logic [NIB_W-1:0]  aux_ch1,
   input logic [NIB_W-1:0]  aux_ch2,
   input logic              hsync,
   input logic              vsync,
   input logic [3:0]        ctl,
   input logic              vde,
   input logic              ade,
   input logic              is_hdmi,
   input logic              dec_err
);

   logic in_ctrl;
   assign in_ctrl = is_ctrl_char(sym_ch0) && is_ctrl_char(sym_ch1) && is_ctrl_char(sym_ch2);

   a_r2_period_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(vde && ade));

   a_r1_ctrl_clears_enables: assert property (@(posedge clk) disable iff (!rst_n)
      (!resync && in_ctrl) |=> (!vde && !ade));

   a_r10_sync_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!resync && !in_ctrl) |=> $stable({hsync, vsync, ctl}));

   a_r10_video_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !vde |-> (pix_ch0 == '0 && pix_ch1 == '0 && pix_ch2 == '0));

   a_r10_aux_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !ade |-> (aux_ch0 == '0 && aux_ch1 == '0 && aux_ch2 == '0));

   a_r7_err_in_island: assert property (@(posedge clk) disable iff (!rst_n)
      dec_err |-> ade);

   a_r4_island_needs_hdmi: assert property (@(posedge clk) disable iff (!rst_n)
      ade |-> is_hdmi);

   a_r6_format_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (is_hdmi && !resync) |=> is_hdmi);

   a_r9_resync_clears: assert property (@(posedge clk) disable iff (!rst_n)
      resync |=> (!vde && !ade && !is_hdmi && !dec_err));

endmodule

bind tmds_period_decoder tmds_period_decoder_chk u_chk (.*);

// File: tb/tmds_period_decoder_tb.sv
module tmds_period_decoder_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       resync = 1'b0;
   logic [9:0] ch0 = '0, ch1 = '0, ch2 = '0;
   logic [7:0] pix0, pix1, pix2;
   logic [3:0] aux0, aux1, aux2;
   logic       hsync, vsync, vde, ade, is_hdmi, dec_err;
   logic [3:0] ctl;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   localparam logic [9:0] GB_MID  = 10'b0100110011;
   localparam logic [9:0] GB_EDGE = 10'b1011001100;

   always #2 clk = ~clk;   // 250 MHz

   tmds_period_decoder u_dut (
      .clk (clk), .rst_n (rst_n), .resync (resync),
      .sym_ch0 (ch0), .sym_ch1 (ch1), .sym_ch2 (ch2),
      .pix_ch0 (pix0), .pix_ch1 (pix1), .pix_ch2 (pix2),
      .aux_ch0 (aux0), .aux_ch1 (aux1), .aux_ch2 (aux2),
      .hsync (hsync), .vsync (vsync), .ctl (ctl),
      .vde (vde), .ade (ade), .is_hdmi (is_hdmi), .dec_err (dec_err)
   );

   function automatic logic [9:0] cc(input int v);
      case (v & 3)
         0:       return 10'b1101010100;
         1:       return 10'b0010101011;
         2:       return 10'b0101010100;
         default: return 10'b1010101011;
      endcase
   endfunction

   function automatic bit is_cc(input logic [9:0] c);
      for (int v = 0; v < 4; v++) if (c == cc(v)) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [9:0] t4(input int n);
      case (n & 15)
         0:  return 10'b1010011100;  1:  return 10'b1001100011;
         2:  return 10'b1011100100;  3:  return 10'b1011100010;
         4:  return 10'b0101110001;  5:  return 10'b0100011110;
         6:  return 10'b0110001110;  7:  return 10'b0100111100;
         8:  return 10'b1011001100;  9:  return 10'b0100111001;
         10: return 10'b0110011100;  11: return 10'b1011000110;
         12: return 10'b1010001110;  13: return 10'b1001110001;
         14: return 10'b0101100011;  default: return 10'b1011000011;
      endcase
   endfunction

   // {valid, index}
   function automatic logic [4:0] t4_idx(input logic [9:0] c);
      for (int n = 0; n < 16; n++) if (c == t4(n)) return {1'b1, 4'(n)};
      return 5'b0;
   endfunction

   function automatic logic [9:0] enc8(input logic [7:0] b, input logic xm, input logic inv);
      logic [7:0] d;
      d[0] = b[0];
      for (int i = 1; i < 8; i++) d[i] = xm ? (d[i-1] ^ b[i]) : ~(d[i-1] ^ b[i]);
      return {inv, xm, inv ? ~d : d};
   endfunction

   function automatic logic [39:0] act_all();
      return {vde, ade, is_hdmi, dec_err, pix0, pix1, pix2, aux0, aux1, aux2};
   endfunction

   task automatic step(input logic [9:0] a, input logic [9:0] b, input logic [9:0] c);
      @(negedge clk);
      ch0 = a; ch1 = b; ch2 = c;
      @(posedge clk);
      #1;
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input logic [39:0] act, input logic [39:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic exp_all(input string req, input string what, input logic [39:0] exp);
      check(act_all() === exp, req, what, act_all(), exp);
   endtask

   // {hsync, vsync, ctl}
   task automatic exp_sync(input string req, input logic [5:0] exp);
      check({hsync, vsync, ctl} === exp, req, "sync/ctl", {34'b0, hsync, vsync, ctl}, {34'b0, exp});
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      logic [9:0] q0, q1, q2;
      logic [4:0] r;

      // R9: reset state
      repeat (3) @(posedge clk);
      #1;
      exp_all("R9", "reset outputs", 40'h0);
      exp_sync("R9", 6'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: every control combination on the three lanes
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++)
            for (int c = 0; c < 4; c++) begin
               step(cc(a), cc(b), cc(c));
               exp_all("R1", "control flags", 40'h0);
               exp_sync("R1", {a[0], a[1], 2'(c), 2'(b)});
            end

      // R2: DVI pixel decode across all bytes and all four mode bits
      for (int m = 0; m < 4; m++)
         for (int b = 0; b < 256; b++) begin
            q0 = enc8(8'(b), m[0], m[1]);
            q1 = enc8(~8'(b), m[0], m[1]);
            q2 = enc8(8'(b) ^ 8'h3c, m[0], m[1]);
            if (!(is_cc(q0) && is_cc(q1) && is_cc(q2))) begin
               step(q0, q1, q2);
               exp_all("R2", "dvi pixel", {4'b1000, 8'(b), ~8'(b), 8'(b) ^ 8'h3c, 12'h0});
            end
         end
      exp_sync("R10", 6'b11_1111);   // held from last control time

      // R8: control time ends video
      step(cc(0), cc(0), cc(0));
      exp_all("R8", "control after video", 40'h0);

      // R5: short preamble, guard decoded as a pixel
      for (int k = 0; k < 7; k++) step(cc(0), cc(1), cc(0));
      step(GB_EDGE, GB_MID, GB_EDGE);
      exp_all("R5", "short preamble guard", {4'b1000, 8'hAB, 8'h55, 8'hAB, 12'h0});
      step(cc(0), cc(0), cc(0));

      // R3: video preamble (longer than the minimum) then guard pair
      for (int k = 0; k < 10; k++) step(cc(2), cc(1), cc(0));
      exp_sync("R3", {1'b0, 1'b1, 4'b0001});
      step(GB_EDGE, GB_MID, GB_EDGE);
      exp_all("R3", "guard 1 consumed", {4'b0010, 24'h0, 12'h0});
      step(GB_EDGE, GB_MID, GB_EDGE);
      exp_all("R3", "guard 2 consumed", {4'b0010, 24'h0, 12'h0});
      for (int i = 0; i < 16; i++) begin
         step(enc8(8'(i * 17), i[0], i[1]), enc8(8'(i), i[1], i[0]), enc8(8'(255 - i), 1'b1, i[2]));
         exp_all("R3", "hdmi video", {4'b1010, 8'(i * 17), 8'(i), 8'(255 - i), 12'h0});
      end
      exp_sync("R10", {1'b0, 1'b1, 4'b0001});
      step(cc(0), cc(0), cc(0));
      exp_all("R8", "control ends hdmi video", {4'b0010, 36'h0});

      // R4: island preamble, guards, all sixteen nibbles
      for (int k = 0; k < 8; k++) step(cc(0), cc(1), cc(1));
      step(t4(12), GB_MID, GB_MID);
      exp_all("R4", "island guard 1", {4'b0010, 36'h0});
      step(t4(12), GB_MID, GB_MID);
      exp_all("R4", "island guard 2", {4'b0010, 36'h0});
      for (int n = 0; n < 16; n++) begin
         step(t4(n), t4(n + 1), t4(n + 2));
         exp_all("R4", "island nibble", {4'b0110, 24'h0, 4'(n), 4'(n + 1), 4'(n + 2)});
      end

      // R7: every 10-bit value on lane 0 inside the island
      for (int v = 0; v < 1024; v++) begin
         if (!is_cc(10'(v))) begin
            r = t4_idx(10'(v));
            step(10'(v), t4(3), t4(9));
            exp_all("R7", "island lane0 sweep",
                    {2'b01, 1'b1, ~r[4], 24'h0, r[3:0], 4'h3, 4'h9});
         end
      end

      // R8: trailing guard pair inside the island
      step(t4(0), GB_MID, GB_MID);
      exp_all("R8", "trailing guard 1", {4'b0010, 36'h0});
      step(t4(0), GB_MID, GB_MID);
      exp_all("R8", "trailing guard 2", {4'b0010, 36'h0});
      step(cc(1), cc(0), cc(0));
      exp_all("R8", "control after island", {4'b0010, 36'h0});
      exp_sync("R1", {1'b1, 1'b0, 4'b0000});

      // R6: format stays HDMI on plain pixel data
      step(enc8(8'h42, 1'b1, 1'b0), enc8(8'h42, 1'b0, 1'b0), enc8(8'h42, 1'b1, 1'b1));
      exp_all("R6", "hdmi held on pixel", {4'b1010, 8'h42, 8'h42, 8'h42, 12'h0});

      // R9/R6: resync clears everything
      @(negedge clk);
      resync = 1'b1;
      ch0 = enc8(8'h10, 1'b1, 1'b0); ch1 = ch0; ch2 = ch0;
      @(posedge clk);
      #1;
      exp_all("R9", "resync clears", 40'h0);
      exp_sync("R9", 6'h0);
      @(negedge clk);
      resync = 1'b0;
      step(enc8(8'h10, 1'b1, 1'b0), enc8(8'h10, 1'b1, 1'b0), enc8(8'h10, 1'b1, 1'b0));
      exp_all("R6", "dvi after resync", {4'b1000, 8'h10, 8'h10, 8'h10, 12'h0});

      // R5: preamble type change restarts the count
      for (int k = 0; k < 4; k++) step(cc(0), cc(1), cc(0));
      for (int k = 0; k < 4; k++) step(cc(0), cc(1), cc(1));
      step(GB_EDGE, GB_MID, GB_EDGE);
      exp_all("R5", "mixed preamble guard", {4'b1000, 8'hAB, 8'h55, 8'hAB, 12'h0});

      done = 1'b1;
      summary();
      $finish;
   end

endmodule